// File: doc/BRIEF.md
# Double-Buffered Video Frame Reader

The block fetches one stored frame at a time from memory through a memory-mapped read master and sends it out as a pixel stream with ready/valid handshaking. Two frame descriptors are held in the register file. Each descriptor holds a base address, a count of memory words, a count of pixels, a width, a height and an interlace code. Software fills a descriptor, selects a slot, sets the run bit, and can take an interrupt at the end of every frame. At each frame boundary the block copies the selected descriptor into a private latch. Software may therefore rewrite either slot while a frame is being sent.

Every frame is sent as two packets. The first is a control packet that carries the latched geometry as 4-bit nibbles. The second is a video packet that holds the pixels unpacked from the memory words. Returned words go into an internal FIFO. A read is issued only when the FIFO has room for it, so back-pressure on the stream never loses data.

A single state machine sequences each frame. Its states are IDLE, CTRL (the control packet, one beat per cycle counted by a beat counter), VHDR (the video header beat) and VBODY (the pixels). Its transitions are: IDLE to CTRL when the run bit is seen set (start); CTRL to VHDR when the last control beat is accepted; VHDR to VBODY when the video header is accepted; VBODY to CTRL when the last pixel is accepted and run is still set (restart); VBODY to IDLE when the last pixel is accepted and run is clear (stop).

Top module: `vfr_top`

## Requirements
- R1: Registers are 32 bits wide and addressed by word. Address 0 holds run in bit 0 and interrupt enable in bit 1. Address 3 holds the slot select in bit 0. Slot s (0 or 1) starts at address 4+7*s and holds, at offsets 0 to 6: base address, word count, pixel count, a reserved word, width (16 bits), height (16 bits) and interlace code (4 bits). The reserved word and all unused bits read as zero.
- R2: Address 1 bit 0 reads 1 while a frame is in progress and 0 in IDLE. The busy state ends only at a frame boundary at which run is clear.
- R3: The end-of-frame flag (address 2, bit 1) is set in the cycle after the last pixel of a frame is accepted. Writing 1 to that bit clears the flag. A set in the same cycle wins over a clear. The irq output equals the flag AND the interrupt enable.
- R4: The selected descriptor is latched when a frame starts. Writes to either slot during a frame do not change that frame.
- R5: Each frame begins with a control packet of 10 beats, each carrying its value in the low bits of the data. The first beat has sop set and carries 0xF. It is followed by the four width nibbles, most significant first, then the four height nibbles in the same order. The last beat carries the interlace code and has eop set.
- R6: After the control packet comes a video packet. Its header beat has sop set and data 0. Then come exactly pixel-count beats, and eop is set on the last one. Each 32-bit memory word holds two 16-bit pixels, and the low half is sent first.
- R7: Reads start at the base address and step by 4 per word, for word-count reads. While wait is high, read and address are held.
- R8: Outstanding reads plus FIFO occupancy never exceed the FIFO depth (8).
- R9: If run is still set when a frame ends, the next frame starts at once with the slot selected at that time.
- R10: While valid is high and ready is low, the stream beat (data, sop, eop) stays unchanged.
- R11: After reset, valid, read and irq are low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | End-of-frame interrupt |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_wait | input | 1 | Wait request from memory |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Stream beat valid |
| st_ready | input | 1 | Stream sink ready |
| st_data | output | 16 | Stream beat data |
| st_sop | output | 1 | Start of packet |
| st_eop | output | 1 | End of packet |

## Verification
The assertions assume that software keeps each descriptor consistent: the word count is the pixel count divided by two and rounded up, and the pixel count is at least 1. They also assume that memory returns exactly one data word for each accepted read, never earlier than the cycle after the request. The stimulus always programs the word count from the pixel count in this way. Its memory model queues each accepted address and returns data from that queue only on later cycles. Wait, data-valid and ready are drawn at random with a fixed seed. Directed frames cover one-pixel and odd-length frames, rewriting a slot mid-frame and a slot switch across back-to-back frames.

// File: rtl/vfr_pkg.sv
package vfr_pkg;
    localparam int REG_AW    = 5;
    localparam int REG_DW    = 32;
    localparam int ADDR_W    = 32;
    localparam int CNT_W     = 32;
    localparam int DIM_W     = 16;
    localparam int ILC_W     = 4;
    localparam int NUM_SLOTS = 2;
    localparam int SLOT_BASE = 4;
    localparam int SLOT_SPAN = 7;

    localparam logic [REG_AW-1:0] A_CTRL = 5'd0;
    localparam logic [REG_AW-1:0] A_STAT = 5'd1;
    localparam logic [REG_AW-1:0] A_IRQ  = 5'd2;
    localparam logic [REG_AW-1:0] A_SEL  = 5'd3;

    localparam logic [REG_AW-1:0] OFF_BASE  = 5'd0;
    localparam logic [REG_AW-1:0] OFF_WORDS = 5'd1;
    localparam logic [REG_AW-1:0] OFF_PATS  = 5'd2;
    localparam logic [REG_AW-1:0] OFF_WID   = 5'd4;
    localparam logic [REG_AW-1:0] OFF_HGT   = 5'd5;
    localparam logic [REG_AW-1:0] OFF_ILC   = 5'd6;

    localparam logic [3:0] HDR_CTRL = 4'hF;
    localparam logic [3:0] HDR_VID  = 4'h0;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  words;
        logic [CNT_W-1:0]  pats;
        logic [DIM_W-1:0]  width;
        logic [DIM_W-1:0]  height;
        logic [ILC_W-1:0]  ilace;
    } frame_desc_t;

    typedef enum logic [1:0] {S_IDLE, S_CTRL, S_VHDR, S_VBODY} rd_state_e;

    function automatic logic [REG_AW-1:0] slot_reg(input int s, input logic [REG_AW-1:0] off);
        return REG_AW'(SLOT_BASE + s * SLOT_SPAN) + off;
    endfunction
endpackage

// File: rtl/vfr_regs.sv
module vfr_regs
    import vfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [REG_DW-1:0] cfg_wdata,
    output logic [REG_DW-1:0] cfg_rdata,
    input  logic              busy,
    input  logic              eof_set,
    output logic              run,
    output logic              irq_en,
    output logic              flag_q,
    output frame_desc_t       sel_desc
);
    logic        slot_sel;
    frame_desc_t slot_q [NUM_SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run      <= 1'b0;
            irq_en   <= 1'b0;
            slot_sel <= 1'b0;
            flag_q   <= 1'b0;
            for (int s = 0; s < NUM_SLOTS; s++) slot_q[s] <= '0;
        end else begin
            if (eof_set)
                flag_q <= 1'b1;
            else if (cfg_wr && cfg_addr == A_IRQ && cfg_wdata[1])
                flag_q <= 1'b0;
            if (cfg_wr) begin
                if (cfg_addr == A_CTRL) begin
                    run    <= cfg_wdata[0];
                    irq_en <= cfg_wdata[1];
                end
                if (cfg_addr == A_SEL) slot_sel <= cfg_wdata[0];
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (cfg_addr == slot_reg(s, OFF_BASE))  slot_q[s].base   <= cfg_wdata[ADDR_W-1:0];
                    if (cfg_addr == slot_reg(s, OFF_WORDS)) slot_q[s].words  <= cfg_wdata[CNT_W-1:0];
                    if (cfg_addr == slot_reg(s, OFF_PATS))  slot_q[s].pats   <= cfg_wdata[CNT_W-1:0];
                    if (cfg_addr == slot_reg(s, OFF_WID))   slot_q[s].width  <= cfg_wdata[DIM_W-1:0];
                    if (cfg_addr == slot_reg(s, OFF_HGT))   slot_q[s].height <= cfg_wdata[DIM_W-1:0];
                    if (cfg_addr == slot_reg(s, OFF_ILC))   slot_q[s].ilace  <= cfg_wdata[ILC_W-1:0];
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            A_CTRL:  cfg_rdata[1:0] = {irq_en, run};
            A_STAT:  cfg_rdata[0]   = busy;
            A_IRQ:   cfg_rdata[1]   = flag_q;
            A_SEL:   cfg_rdata[0]   = slot_sel;
            default: ;
        endcase
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (cfg_addr == slot_reg(s, OFF_BASE))  cfg_rdata = REG_DW'(slot_q[s].base);
            if (cfg_addr == slot_reg(s, OFF_WORDS)) cfg_rdata = REG_DW'(slot_q[s].words);
            if (cfg_addr == slot_reg(s, OFF_PATS))  cfg_rdata = REG_DW'(slot_q[s].pats);
            if (cfg_addr == slot_reg(s, OFF_WID))   cfg_rdata = REG_DW'(slot_q[s].width);
            if (cfg_addr == slot_reg(s, OFF_HGT))   cfg_rdata = REG_DW'(slot_q[s].height);
            if (cfg_addr == slot_reg(s, OFF_ILC))   cfg_rdata = REG_DW'(slot_q[s].ilace);
        end
    end

    assign sel_desc = slot_q[slot_sel];
endmodule

// File: rtl/vfr_fifo.sv
module vfr_fifo #(
    parameter int W = 32,
    parameter int D = 8,
    localparam int PW = $clog2(D),
    localparam int LW = $clog2(D + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [D];
    logic [PW-1:0] wp, rp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            level <= level + LW'(push) - LW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign empty = (level == '0);
endmodule

// File: rtl/vfr_fetch.sv
module vfr_fetch
    import vfr_pkg::*;
#(
    parameter int BYTES = 4,
    parameter int FD    = 8,
    localparam int LW   = $clog2(FD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  words,
    input  logic [LW-1:0]     level,
    input  logic              mem_wait,
    input  logic              mem_rvalid,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LW-1:0]     pend_q
);
    logic [CNT_W-1:0] left_q;
    logic             accept;

    assign mem_rd = (left_q != '0) &&
                    (({1'b0, pend_q} + {1'b0, level}) < (LW + 1)'(FD));
    assign accept = mem_rd && !mem_wait;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            left_q   <= '0;
            pend_q   <= '0;
        end else begin
            if (start) begin
                mem_addr <= base;
                left_q   <= words;
            end else if (accept) begin
                mem_addr <= mem_addr + ADDR_W'(BYTES);
                left_q   <= left_q - 1'b1;
            end
            pend_q <= pend_q + LW'(accept) - LW'(mem_rvalid);
        end
    end
endmodule

// File: rtl/vfr_top.sv
module vfr_top
    import vfr_pkg::*;
#(
    parameter int PIX_W        = 16,
    parameter int PIX_PER_WORD = 2,
    parameter int FIFO_DEPTH   = 8,
    localparam int WORD_W      = PIX_W * PIX_PER_WORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [REG_DW-1:0] cfg_wdata,
    output logic [REG_DW-1:0] cfg_rdata,
    output logic              irq,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wait,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [PIX_W-1:0]  st_data,
    output logic              st_sop,
    output logic              st_eop
);
    localparam int NIB       = DIM_W / 4;
    localparam int CB_LAST   = 2 * NIB + 1;
    localparam int BW        = $clog2(CB_LAST + 1);
    localparam int SUB_W     = (PIX_PER_WORD > 1) ? $clog2(PIX_PER_WORD) : 1;
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(PIX_PER_WORD - 1);

    rd_state_e         state;
    logic [BW-1:0]     beat;
    logic [SUB_W-1:0]  sub;
    logic [CNT_W-1:0]  pix_left;
    frame_desc_t       desc_q, sel_desc;
    logic              run, irq_en, flag_q;
    logic              busy, in_vid, fire, last_pix, start, pop;
    logic [WORD_W-1:0] fifo_dout;
    logic              fifo_empty;
    logic [LVL_W-1:0]  fifo_level;
    logic [LVL_W-1:0]  pend;

    assign busy     = (state != S_IDLE);
    assign in_vid   = (state == S_VBODY);
    assign fire     = st_valid && st_ready;
    assign last_pix = in_vid && fire && (pix_left == CNT_W'(1));
    assign start    = run && ((state == S_IDLE) || last_pix);
    assign irq      = flag_q && irq_en;

    vfr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
        .eof_set(last_pix), .run(run), .irq_en(irq_en), .flag_q(flag_q),
        .sel_desc(sel_desc)
    );

    vfr_fetch #(.BYTES(WORD_W / 8), .FD(FIFO_DEPTH)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(start), .base(sel_desc.base),
        .words(sel_desc.words), .level(fifo_level), .mem_wait(mem_wait),
        .mem_rvalid(mem_rvalid), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .pend_q(pend)
    );

    vfr_fifo #(.W(WORD_W), .D(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(mem_rvalid), .din(mem_rdata),
        .pop(pop), .dout(fifo_dout), .empty(fifo_empty), .level(fifo_level)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            beat     <= '0;
            sub      <= '0;
            pix_left <= '0;
            desc_q   <= '0;
        end else if (start) begin
            desc_q <= sel_desc;
            state  <= S_CTRL;
            beat   <= '0;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_CTRL: if (fire) begin
                    if (beat == BW'(CB_LAST)) state <= S_VHDR;
                    beat <= beat + 1'b1;
                end
                S_VHDR: if (fire) begin
                    state    <= S_VBODY;
                    sub      <= '0;
                    pix_left <= desc_q.pats;
                end
                S_VBODY: if (fire) begin
                    pix_left <= pix_left - 1'b1;
                    sub      <= (sub == LAST_SUB) ? '0 : sub + 1'b1;
                    if (pix_left == CNT_W'(1)) state <= S_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        st_valid = 1'b0;
        st_data  = '0;
        st_sop   = 1'b0;
        st_eop   = 1'b0;
        pop      = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_CTRL: begin
                st_valid = 1'b1;
                if (beat == '0) begin
                    st_data = PIX_W'(HDR_CTRL);
                    st_sop  = 1'b1;
                end else if (int'(beat) <= NIB) begin
                    st_data = PIX_W'(desc_q.width[4 * (NIB - int'(beat)) +: 4]);
                end else if (int'(beat) <= 2 * NIB) begin
                    st_data = PIX_W'(desc_q.height[4 * (2 * NIB - int'(beat)) +: 4]);
                end else begin
                    st_data = PIX_W'(desc_q.ilace);
                    st_eop  = 1'b1;
                end
            end
            S_VHDR: begin
                st_valid = 1'b1;
                st_data  = PIX_W'(HDR_VID);
                st_sop   = 1'b1;
            end
            S_VBODY: begin
                st_valid = !fifo_empty;
                st_data  = fifo_dout[int'(sub) * PIX_W +: PIX_W];
                st_eop   = (pix_left == CNT_W'(1));
                pop      = !fifo_empty && st_ready &&
                           ((sub == LAST_SUB) || (pix_left == CNT_W'(1)));
            end
        endcase
    end
endmodule

// File: rtl/vfr_chk.sv
module vfr_chk #(
    parameter int AW    = 32,
    parameter int DW    = 16,
    parameter int FD    = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wait,
    input logic [AW-1:0] mem_addr,
    input logic          st_valid,
    input logic          st_ready,
    input logic [DW-1:0] st_data,
    input logic          st_sop,
    input logic          st_eop,
    input logic          busy,
    input logic          in_vid,
    input logic          flag,
    input logic [LW-1:0] pend,
    input logic [LW-1:0] level
);
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && mem_wait |=> mem_rd && $stable(mem_addr));

    p_credit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pend) + int'(level)) <= FD);

    p_beat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_sop) && $stable(st_eop));

    p_eof_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_vid && st_valid && st_ready && st_eop |=> flag);

    p_read_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);
endmodule

bind vfr_top vfr_chk #(
    .AW(vfr_pkg::ADDR_W), .DW(PIX_W), .FD(FIFO_DEPTH), .LW(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wait(mem_wait),
    .mem_addr(mem_addr), .st_valid(st_valid), .st_ready(st_ready),
    .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop), .busy(busy),
    .in_vid(in_vid), .flag(flag_q), .pend(pend), .level(fifo_level)
);

// File: tb/test_vfr_top.sv
module test_vfr_top;
    localparam int CLK_PERIOD = 10;
    localparam int FD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_wait = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        st_valid;
    logic        st_ready = 1'b0;
    logic [15:0] st_data;
    logic        st_sop, st_eop;

    int total = 0, bad = 0;
    int wait_pct = 0, rdy_pct = 100;
    int outst = 0, max_outst = 0, stall_n = 0, hold_bad = 0;
    bit prev_stall = 0, done = 0;
    logic [17:0] prev_beat;
    logic [31:0] q_addr[$], got_addr[$], exp_addr[$];
    logic [17:0] cap[$], exp_q[$];

    vfr_top i_vfr_top (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wait(mem_wait),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .st_valid(st_valid),
        .st_ready(st_ready), .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[17:2] + 16'h0101};
    endfunction

    // monitor at the clock edge
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_rd && !mem_wait) begin
                q_addr.push_back(mem_addr);
                got_addr.push_back(mem_addr);
                outst++;
            end
            if (mem_rvalid) outst--;
            if (outst > max_outst) max_outst = outst;
            if (prev_stall) begin
                stall_n++;
                if (!st_valid || {st_sop, st_eop, st_data} != prev_beat) hold_bad++;
            end
            prev_stall = st_valid && !st_ready;
            prev_beat  = {st_sop, st_eop, st_data};
            if (st_valid && st_ready) cap.push_back({st_sop, st_eop, st_data});
        end
    end

    // memory and sink drivers away from the edge
    always @(negedge clk) begin
        mem_wait <= (int'($urandom % 100) < wait_pct);
        st_ready <= (int'($urandom % 100) < rdy_pct);
        if (q_addr.size() > 0 && ($urandom % 100) < 60) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= memf(q_addr.pop_front());
        end else begin
            mem_rvalid <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = 5'(a);
        #1 d = cfg_rdata;
    endtask

    function automatic int sa(input int s, input int off);
        return 4 + 7 * s + off;
    endfunction

    task automatic set_slot(input int s, input logic [31:0] base, input int pats,
                            input logic [15:0] w, input logic [15:0] h, input logic [3:0] il);
        wr(sa(s, 0), base);
        wr(sa(s, 1), 32'((pats + 1) / 2));
        wr(sa(s, 2), 32'(pats));
        wr(sa(s, 4), {16'h0, w});
        wr(sa(s, 5), {16'h0, h});
        wr(sa(s, 6), {28'h0, il});
    endtask

    task automatic build_exp(input logic [31:0] base, input int pats,
                             input logic [15:0] w, input logic [15:0] h, input logic [3:0] il);
        exp_q.push_back({2'b10, 16'h000F});
        for (int i = 0; i < 4; i++) exp_q.push_back({2'b00, 12'h0, w[4 * (3 - i) +: 4]});
        for (int i = 0; i < 4; i++) exp_q.push_back({2'b00, 12'h0, h[4 * (3 - i) +: 4]});
        exp_q.push_back({2'b01, 12'h0, il});
        exp_q.push_back({2'b10, 16'h0000});
        for (int i = 0; i < pats; i++) begin
            logic [31:0] wd;
            wd = memf(base + 32'(4 * (i / 2)));
            exp_q.push_back({1'b0, (i == pats - 1), wd[16 * (i % 2) +: 16]});
        end
        for (int k = 0; k < (pats + 1) / 2; k++) exp_addr.push_back(base + 32'(4 * k));
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            rd(1, d);
            if (d[0] == 1'b0) break;
        end
    endtask

    task automatic cmp(input string req);
        int mism = 0, amis = 0;
        chk(cap.size() == exp_q.size(), req, "beat count", cap.size(), exp_q.size());
        for (int i = 0; i < cap.size() && i < exp_q.size(); i++)
            if (cap[i] !== exp_q[i]) mism++;
        chk(mism == 0, req, "beat mismatches", mism, 0);
        chk(got_addr.size() == exp_addr.size(), "R7", "read count", got_addr.size(), exp_addr.size());
        for (int i = 0; i < got_addr.size() && i < exp_addr.size(); i++)
            if (got_addr[i] !== exp_addr[i]) amis++;
        chk(amis == 0, "R7", "address mismatches", amis, 0);
        cap.delete(); exp_q.delete(); got_addr.delete(); exp_addr.delete();
    endtask

    task automatic run_single();
        wr(0, 32'h3);
        wr(0, 32'h2);
        wait_idle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(st_valid == 0 && mem_rd == 0 && irq == 0, "R11", "outputs after reset",
            {st_valid, mem_rd, irq}, 0);
        rd(1, d); chk(d == 0, "R11", "status after reset", d, 0);
        rd(sa(1, 4), d); chk(d == 0, "R11", "slot reg after reset", d, 0);

        // R1 register map
        wr(sa(1, 4), 32'hABCD_1234);
        rd(sa(1, 4), d); chk(d == 32'h1234, "R1", "width readback", d, 32'h1234);
        wr(sa(1, 3), 32'hFFFF_FFFF);
        rd(sa(1, 3), d); chk(d == 0, "R1", "reserved reads zero", d, 0);
        wr(sa(0, 6), 32'hFFFF_FFFF);
        rd(sa(0, 6), d); chk(d == 32'hF, "R1", "interlace width", d, 32'hF);
        wr(0, 32'hFFFF_FFFE);
        rd(0, d); chk(d == 32'h2, "R1", "control readback", d, 32'h2);
        wr(3, 32'h1);
        rd(3, d); chk(d == 32'h1, "R1", "select readback", d, 32'h1);
        wr(3, 32'h0);

        // single frame, one pixel, free-flowing (R5 R6 R3 R2)
        set_slot(0, 32'h0000_1000, 1, 16'h1E2F, 16'h0438, 4'h3);
        rd(sa(0, 0), d); chk(d == 32'h1000, "R1", "base readback", d, 32'h1000);
        build_exp(32'h0000_1000, 1, 16'h1E2F, 16'h0438, 4'h3);
        run_single();
        cmp("R5/R6");
        rd(1, d); chk(d[0] == 0, "R2", "busy clear after stop", d, 0);
        chk(irq == 1, "R3", "irq after frame", irq, 1);
        rd(2, d); chk(d == 32'h2, "R3", "flag bit", d, 32'h2);
        wr(2, 32'h2);
        @(negedge clk);
        chk(irq == 0, "R3", "irq after clear", irq, 0);

        // odd length, back-pressure, waits (R6 R8 R10)
        wait_pct = 50; rdy_pct = 40;
        set_slot(1, 32'h0000_2000, 13, 16'h0280, 16'h01E0, 4'hA);
        wr(3, 32'h1);
        build_exp(32'h0000_2000, 13, 16'h0280, 16'h01E0, 4'hA);
        run_single();
        cmp("R6");

        // back-to-back frames, mid-frame rewrite and slot switch (R4 R9)
        wait_pct = 20; rdy_pct = 70;
        wr(2, 32'h2);
        wr(3, 32'h0);
        set_slot(0, 32'h0000_3000, 9, 16'h0100, 16'h0200, 4'h5);
        set_slot(1, 32'h0000_4000, 6, 16'h0333, 16'h0444, 4'h6);
        build_exp(32'h0000_3000, 9, 16'h0100, 16'h0200, 4'h5);
        build_exp(32'h0000_4000, 6, 16'h0333, 16'h0444, 4'h6);
        wr(0, 32'h3);
        repeat (3) @(negedge clk);
        wr(3, 32'h1);
        wr(sa(0, 4), 32'h0000_0FFF);
        wr(sa(0, 2), 32'd2);
        while (!irq) @(negedge clk);
        wr(0, 32'h2);
        wr(2, 32'h2);
        wait_idle();
        repeat (3) @(negedge clk);
        cmp("R4/R9");
        chk(irq == 1, "R3", "flag set by second frame", irq, 1);

        // randomized single frames
        for (int it = 0; it < 6; it++) begin
            int s, pats;
            logic [31:0] base;
            logic [15:0] w, h;
            logic [3:0]  il;
            s = int'($urandom % 2);
            pats = 1 + int'($urandom % 24);
            base = {18'h0, 12'($urandom), 2'b00};
            w = 16'($urandom); h = 16'($urandom); il = 4'($urandom);
            wait_pct = int'($urandom % 70);
            rdy_pct = 20 + int'($urandom % 81);
            set_slot(s, base, pats, w, h, il);
            wr(3, 32'(s));
            build_exp(base, pats, w, h, il);
            run_single();
            cmp("R6");
        end

        chk(max_outst <= FD, "R8", "outstanding reads", max_outst, FD);
        chk(hold_bad == 0 && stall_n > 0, "R10", "held beats changed", hold_bad, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule